// File: doc/BRIEF.md
# Multiplexed-Address DRAM Array Model

A synthesizable behavioural model of a very small DRAM device. Storage is a grid of byte-wide cells, four rows by four columns by default, which gives 128 bits in total. A single narrow address bus is shared in time between the row index and the column index. Its width is the larger of the two index widths, which is 2 bits by default.

A row strobe latches the bus as a row index and copies that whole row into an internal row buffer. A following column strobe latches the bus as a column index and serves one cell out of that buffer. On a read, the byte appears on the read data pins one clock later. On a write, the write data pins update the buffered cell and the stored row together. A column strobe that arrives while no row is open does nothing except raise an error flag. Refresh, sensing, analog timing and banking are not modelled.

Top module: `dram_mux_array`

## Requirements
- R1: After an asynchronous reset (rst_ni low), rdata_o is 0, rvalid_o is 0, row_open_o is 0, col_err_o is 0, and every stored cell holds 0.
- R2: A row strobe latches addr_i[1:0] as the row index and loads that row into the buffer. After that edge, row_open_o is 1, rvalid_o is 0 and col_err_o is 0.
- R3: A column strobe with a row open and we_i low latches addr_i[1:0] as the column index. One clock later, rdata_o equals the cell at (open row, that column) and rvalid_o is 1.
- R4: While neither strobe is asserted, rdata_o and rvalid_o keep their values.
- R5: A column strobe with a row open and we_i high writes wdata_i into the buffered cell and into the stored row in the same edge, and drives rvalid_o to 0. A later read of that cell returns the new value, both from the same open row and after the row is opened again.
- R6: A column strobe while no row is open leaves rdata_o, rvalid_o and the stored cells unchanged. It sets col_err_o, which stays at 1 until the next row strobe.
- R7: When both strobes are asserted in the same cycle, only the row strobe is served. The column strobe is dropped without a read, without a write, and without an error.
- R8: A write changes only the addressed cell. Every other cell keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_stb_i | input | 1 | Row strobe: latch addr_i as the row index and load the row buffer |
| col_stb_i | input | 1 | Column strobe: latch addr_i as the column index and access the buffer |
| we_i | input | 1 | Write enable, sampled with the column strobe |
| addr_i | input | 2 | Shared row and column index bus |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Read data byte |
| rvalid_o | output | 1 | rdata_o holds the result of the latest column read |
| row_open_o | output | 1 | A row has been latched into the buffer |
| col_err_o | output | 1 | A column strobe arrived while no row was open |

## Verification
The assertions assume that the strobes, we_i, addr_i and wdata_i change only away from the rising edge. They also assume that a strobe lasts exactly one cycle for each access, so that each strobe counts as one distinct command. The bench drives every input on the falling edge and holds each strobe for a single cycle. It samples outputs on the next falling edge, when the design has registered the command. It compares each result with a reference byte array that it keeps in step with its own writes.

// File: rtl/dram_pkg.sv
package dram_pkg;
  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int idx_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/dram_row_store.sv
module dram_row_store #(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int WORD_W = 8,
  localparam int RA_W  = dram_pkg::idx_w(ROWS),
  localparam int CA_W  = dram_pkg::idx_w(COLS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [RA_W-1:0]              rd_row_i,
  output logic [COLS-1:0][WORD_W-1:0]  rd_data_o,
  input  logic                         wr_en_i,
  input  logic [RA_W-1:0]              wr_row_i,
  input  logic [CA_W-1:0]              wr_col_i,
  input  logic [WORD_W-1:0]            wr_data_i
);
  logic [ROWS-1:0][COLS-1:0][WORD_W-1:0] cells_q;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam logic [RA_W-1:0] RIDX = RA_W'(r);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cells_q[r] <= '0;
      end else if (wr_en_i && (wr_row_i == RIDX)) begin
        cells_q[r][wr_col_i] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = cells_q[rd_row_i];
endmodule

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl #(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  localparam int RA_W  = dram_pkg::idx_w(ROWS),
  localparam int CA_W  = dram_pkg::idx_w(COLS),
  localparam int ADDR_W = dram_pkg::max_int(RA_W, CA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              row_stb_i,
  input  logic              col_stb_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [RA_W-1:0]   row_q_o,
  output logic [CA_W-1:0]   col_o,
  output logic              load_o,
  output logic              rd_go_o,
  output logic              wr_go_o,
  output logic              row_open_o,
  output logic              col_err_o
);
  logic col_ok, col_bad;

  // row strobe wins a same-cycle collision
  assign col_ok  = col_stb_i && !row_stb_i && row_open_o;
  assign col_bad = col_stb_i && !row_stb_i && !row_open_o;

  assign load_o  = row_stb_i;
  assign rd_go_o = col_ok && !we_i;
  assign wr_go_o = col_ok && we_i;
  assign col_o   = addr_i[CA_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q_o    <= '0;
      row_open_o <= 1'b0;
      col_err_o  <= 1'b0;
    end else if (row_stb_i) begin
      row_q_o    <= addr_i[RA_W-1:0];
      row_open_o <= 1'b1;
      col_err_o  <= 1'b0;
    end else if (col_bad) begin
      col_err_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/dram_row_buffer.sv
module dram_row_buffer #(
  parameter int COLS   = 4,
  parameter int WORD_W = 8,
  localparam int CA_W  = dram_pkg::idx_w(COLS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic [COLS-1:0][WORD_W-1:0]  load_row_i,
  input  logic                         rd_go_i,
  input  logic                         wr_go_i,
  input  logic [CA_W-1:0]              col_i,
  input  logic [WORD_W-1:0]            wdata_i,
  output logic [WORD_W-1:0]            rdata_o,
  output logic                         rvalid_o
);
  logic [COLS-1:0][WORD_W-1:0] buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q    <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else if (load_i) begin
      buf_q    <= load_row_i;
      rvalid_o <= 1'b0;
    end else if (wr_go_i) begin
      buf_q[col_i] <= wdata_i;
      rvalid_o     <= 1'b0;
    end else if (rd_go_i) begin
      rdata_o  <= buf_q[col_i];
      rvalid_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dram_mux_array.sv
module dram_mux_array #(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int WORD_W = 8,
  localparam int RA_W  = dram_pkg::idx_w(ROWS),
  localparam int CA_W  = dram_pkg::idx_w(COLS),
  localparam int ADDR_W = dram_pkg::max_int(RA_W, CA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              row_stb_i,
  input  logic              col_stb_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              row_open_o,
  output logic              col_err_o
);
  logic [RA_W-1:0]             row_q;
  logic [CA_W-1:0]             col;
  logic                        load, rd_go, wr_go;
  logic [COLS-1:0][WORD_W-1:0] row_data;

  dram_strobe_ctrl #(.ROWS(ROWS), .COLS(COLS)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .row_stb_i  (row_stb_i),
    .col_stb_i  (col_stb_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .row_q_o    (row_q),
    .col_o      (col),
    .load_o     (load),
    .rd_go_o    (rd_go),
    .wr_go_o    (wr_go),
    .row_open_o (row_open_o),
    .col_err_o  (col_err_o)
  );

  dram_row_store #(.ROWS(ROWS), .COLS(COLS), .WORD_W(WORD_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_row_i  (addr_i[RA_W-1:0]),
    .rd_data_o (row_data),
    .wr_en_i   (wr_go),
    .wr_row_i  (row_q),
    .wr_col_i  (col),
    .wr_data_i (wdata_i)
  );

  dram_row_buffer #(.COLS(COLS), .WORD_W(WORD_W)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_row_i (row_data),
    .rd_go_i    (rd_go),
    .wr_go_i    (wr_go),
    .col_i      (col),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o)
  );
endmodule

// File: rtl/dram_mux_array_chk.sv
module dram_mux_array_chk #(
  parameter int ADDR_W = 2,
  parameter int WORD_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              row_stb_i,
  input logic              col_stb_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [WORD_W-1:0] wdata_i,
  input logic [WORD_W-1:0] rdata_o,
  input logic              rvalid_o,
  input logic              row_open_o,
  input logic              col_err_o
);
  a_r2_row_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_stb_i |=> row_open_o && !rvalid_o && !col_err_o);

  a_r2_open_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_open_o |=> row_open_o);

  a_r3_read_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_stb_i && !row_stb_i && row_open_o && !we_i) |=> rvalid_o);

  a_r4_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!row_stb_i && !col_stb_i) |=> $stable(rdata_o) && $stable(rvalid_o));

  a_r5_write_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_stb_i && !row_stb_i && row_open_o && we_i) |=> !rvalid_o && $stable(rdata_o));

  a_r6_err_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_stb_i && !row_stb_i && !row_open_o) |=> col_err_o && $stable(rdata_o) && $stable(rvalid_o));

  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_err_o && !row_stb_i) |=> col_err_o);

  a_r6_err_needs_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_err_o |-> !row_open_o);
endmodule

bind dram_mux_array dram_mux_array_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/sim_dram_mux_array.sv
`timescale 1ns/1ps
module sim_dram_mux_array;
  localparam int ROWS = 4;
  localparam int COLS = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       row_stb_i = 1'b0, col_stb_i = 1'b0, we_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       rvalid_o, row_open_o, col_err_o;

  int total = 0;
  int bad = 0;
  logic [7:0] ref_mem [ROWS*COLS];
  logic [7:0] last_rd;

  always #10 clk_i = ~clk_i;

  dram_mux_array u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic open_row(input int r);
    row_stb_i = 1'b1; addr_i = 2'(r);
    @(negedge clk_i);
    row_stb_i = 1'b0;
  endtask

  task automatic col_op(input int c, input logic w, input logic [7:0] d);
    col_stb_i = 1'b1; we_i = w; addr_i = 2'(c); wdata_i = d;
    @(negedge clk_i);
    col_stb_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic read_chk(input string tag, input int r, input int c);
    col_op(c, 1'b0, 8'h00);
    chk({tag, " rvalid"}, int'(rvalid_o), 1);
    chk({tag, " rdata"}, int'(rdata_o), int'(ref_mem[r*COLS+c]));
    last_rd = rdata_o;
  endtask

  task automatic t_reset();
    chk("R1 rdata", int'(rdata_o), 0);
    chk("R1 rvalid", int'(rvalid_o), 0);
    chk("R1 row_open", int'(row_open_o), 0);
    chk("R1 col_err", int'(col_err_o), 0);
  endtask

  task automatic t_no_row();
    col_op(2, 1'b1, 8'hEE);
    chk("R6 err set", int'(col_err_o), 1);
    chk("R6 rvalid", int'(rvalid_o), 0);
    chk("R6 rdata", int'(rdata_o), 0);
    @(negedge clk_i);
    chk("R6 err sticky", int'(col_err_o), 1);
    open_row(0);
    chk("R6 err cleared", int'(col_err_o), 0);
    chk("R2 open", int'(row_open_o), 1);
    read_chk("R6 no write r0c2", 0, 2);
    for (int c = 0; c < COLS; c++) read_chk("R1 zero cell", 0, c);
  endtask

  task automatic t_fill();
    for (int r = 0; r < ROWS; r++) begin
      open_row(r);
      chk("R2 rvalid clr", int'(rvalid_o), 0);
      for (int c = 0; c < COLS; c++) begin
        logic [7:0] v;
        v = 8'(8'h31 * (r + 1) + 8'h07 * c + 8'h5A);
        col_op(c, 1'b1, v);
        ref_mem[r*COLS+c] = v;
        chk("R5 write rvalid", int'(rvalid_o), 0);
      end
    end
  endtask

  task automatic t_read_all();
    for (int r = ROWS - 1; r >= 0; r--) begin
      open_row(r);
      chk("R2 row_open", int'(row_open_o), 1);
      for (int c = 0; c < COLS; c++) read_chk("R3 read", r, c);
    end
  endtask

  task automatic t_hold();
    open_row(2);
    read_chk("R3 pre-hold", 2, 3);
    repeat (3) @(negedge clk_i);
    chk("R4 rvalid held", int'(rvalid_o), 1);
    chk("R4 rdata held", int'(rdata_o), int'(last_rd));
  endtask

  task automatic t_write_same_row();
    open_row(1);
    col_op(2, 1'b1, 8'hA5);
    ref_mem[1*COLS+2] = 8'hA5;
    read_chk("R5 same row", 1, 2);
    open_row(3);
    open_row(1);
    read_chk("R5 reopen", 1, 2);
    read_chk("R8 neighbour c1", 1, 1);
    read_chk("R8 neighbour c3", 1, 3);
    open_row(2);
    read_chk("R8 other row c2", 2, 2);
  endtask

  task automatic t_both();
    open_row(0);
    read_chk("R7 setup", 0, 1);
    row_stb_i = 1'b1; col_stb_i = 1'b1; we_i = 1'b1; addr_i = 2'd3; wdata_i = 8'h00;
    @(negedge clk_i);
    row_stb_i = 1'b0; col_stb_i = 1'b0; we_i = 1'b0;
    chk("R7 rvalid", int'(rvalid_o), 0);
    chk("R7 no err", int'(col_err_o), 0);
    read_chk("R7 new row, no write", 3, 3);
    read_chk("R7 new row c0", 3, 0);
  endtask

  initial begin
    for (int i = 0; i < ROWS*COLS; i++) ref_mem[i] = 8'h00;
    last_rd = 8'h00;
    repeat (2) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_no_row();
    t_fill();
    t_read_all();
    t_hold();
    t_write_same_row();
    t_both();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule